// File: doc/BRIEF.md
# EEPROM Configuration Image Validator

This block keeps a copy of a 64-word by 16-bit configuration image that lives in a serial EEPROM. It reaches that EEPROM only through a Microwire master's command port. A load request reads the whole image into an internal register file. The block then checks the image in two ways: its 16-bit wrapping sum must match a fixed target, and a two-bit signature field must hold the expected value. If either check fails, the first 63 words are replaced with a built-in default image. Once loading finishes, the result is shown on two flags and marked with a single-cycle pulse.

The host reads and writes image words through a simple word port. While the block is idle, the host can also edit the 48-bit station address held in the first three words. A program request then writes the image back to the EEPROM. The block first sends a write-enable command and then writes every word in ascending order. The last word is replaced with a checksum chosen so that the total sum of the image equals the target again.

Top module: `eeprom_cfg_validator`

## Requirements
- R1: After reset, busy, mwReq, loadDone, imageValid and defaultsUsed are 0, and every register-file word reads 0 on hostRData.
- R2: A load issues exactly 64 READ commands (mwOp = 2'b10) at addresses 0, 1, ..., 63 in ascending order. Each command holds mwReq, mwOp, mwAddr and mwWData steady until the cycle in which mwDone is seen, and the word read is mwRdData from that cycle.
- R3: When the 16-bit wrapping sum of all 64 loaded words equals 0xBABA and bits [15:14] of word 10 equal 2'b01, the loaded image is kept unchanged, imageValid becomes 1 and defaultsUsed becomes 0.
- R4: When the sum check fails, words 0 to 62 are replaced by the default image and word 63 keeps its loaded value. The defaults are: words 0-9 = 0x0000; 10 = 0x4E0B; 11 = 0x1008; 12 = 0x8086; 13 = 0x1008; 14 = 0x8086; 15 = 0xF02C; 16-31 = 0xFFFF; 32 = 0xDFDE; 33 = 0x0002; 34 = 0x1414; 35-62 = 0xFFFF. After this, imageValid is 0 and defaultsUsed is 1.
- R5: When the sum is correct but bits [15:14] of word 10 are not 2'b01, the defaults are applied exactly as in R4.
- R6: loadDone is a one-cycle pulse. The flags take their new values in the same cycle, busy is already 0 in that cycle, and imageValid and defaultsUsed are never both 1.
- R7: A program request issues one WREN command (mwOp = 2'b11, mwAddr = 0) and then 64 WRITE commands (mwOp = 2'b01) at addresses 0 to 63 in ascending order. Words 0 to 62 are sent with their register-file values. Word 63 is sent as 0xBABA minus the 16-bit sum of words 0 to 62, and that same value is also stored in register-file word 63.
- R8: While busy is 0, a write from hostWe stores hostWData at hostAddr, and the new value is visible on hostRData in the next cycle. hostRData always shows the word at hostAddr.
- R9: While busy is 1, host writes are ignored, and startLoad and startProg are ignored.
- R10: stationAddr is {word2, word1, word0}, so station byte k appears on bits [8k+7:8k]. Byte 0 is therefore the low byte of word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startLoad | input | 1 | Request to load and validate the image (takes priority over startProg) |
| startProg | input | 1 | Request to write the image back with a new checksum |
| mwReq | output | 1 | Command valid to the Microwire master |
| mwOp | output | 2 | Command: 10 read, 01 write, 11 write-enable |
| mwAddr | output | 6 | Word address of the command |
| mwWData | output | 16 | Write data of the command |
| mwDone | input | 1 | Master has finished the current command |
| mwRdData | input | 16 | Read data, valid together with mwDone |
| hostAddr | input | 6 | Host word address |
| hostWe | input | 1 | Host write strobe |
| hostWData | input | 16 | Host write data |
| hostRData | output | 16 | Register-file word at hostAddr |
| busy | output | 1 | A load or program sequence is running |
| loadDone | output | 1 | One-cycle pulse when loading ends |
| imageValid | output | 1 | Loaded image passed both checks |
| defaultsUsed | output | 1 | Default image was substituted |
| stationAddr | output | 48 | Station address from words 0 to 2 |

## Verification
Validation is tried with three images.

- A self-consistent image shows that the block keeps what it read.
- An image with a single flipped bit outside the signature word shows that the sum check alone forces the defaults, while word 63 keeps its loaded value.
- An image with a correct sum but a wrong signature shows that the signature check acts independently of the sum.

Programming follows a host edit to a station-address word, so the checksum the block writes must differ from the one it loaded. A load with a host write and a program request injected mid-sequence shows that requests made while busy are dropped.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WREN  = 2'b11;

  typedef struct packed {
    logic clrCnt;        // restart index and running sum
    logic loadStep;      // capture read word, accumulate, advance
    logic progStep;      // accumulate sent word, advance, store checksum
    logic applyDefaults; // overwrite words 0..62 with built-in image
  } ctl_t;

  function automatic logic [15:0] defaultWord(input int unsigned n);
    logic [15:0] w;
    if (n < 10)                     w = 16'h0000;
    else if (n >= 16 && n <= 31)    w = 16'hFFFF;
    else if (n >= 35)               w = 16'hFFFF;
    else begin
      case (n)
        10:      w = 16'h4E0B;
        11, 13:  w = 16'h1008;
        12, 14:  w = 16'h8086;
        15:      w = 16'hF02C;
        32:      w = 16'hDFDE;
        33:      w = 16'h0002;
        34:      w = 16'h1414;
        default: w = 16'hFFFF;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/eecfg_datapath.sv
module eecfg_datapath
  import eecfg_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int SIG_WORD = 10,
  parameter logic [DW-1:0] SUM_TARGET = 16'hBABA
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mwRdData,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWData,
  output logic [DW-1:0] hostRData,
  output logic [AW-1:0] idx,
  output logic          lastIdx,
  output logic          sumOk,
  output logic          sigOk,
  output logic [DW-1:0] outWord,
  output logic [3*DW-1:0] stationAddr
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] regs [WORDS];
  logic [DW-1:0] sum;

  assign lastIdx     = (idx == AW'(WORDS - 1));
  assign outWord     = lastIdx ? (SUM_TARGET - sum) : regs[idx];
  assign sumOk       = (sum == SUM_TARGET);
  assign sigOk       = (regs[SIG_WORD][DW-1:DW-2] == 2'b01);
  assign hostRData   = regs[hostAddr];
  assign stationAddr = {regs[2], regs[1], regs[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) regs[i] <= '0;
      idx <= '0;
      sum <= '0;
    end else begin
      if (ctl.clrCnt) begin
        idx <= '0;
        sum <= '0;
      end
      if (ctl.loadStep) begin
        regs[idx] <= mwRdData;
        sum       <= sum + mwRdData;
        idx       <= idx + 1'b1;
      end
      if (ctl.progStep) begin
        sum <= sum + outWord;
        idx <= idx + 1'b1;
        if (lastIdx) regs[idx] <= outWord;
      end
      if (ctl.applyDefaults)
        for (int i = 0; i < WORDS - 1; i++) regs[i] <= DW'(defaultWord(i));
      if (hostWe) regs[hostAddr] <= hostWData;
    end
  end
endmodule

// File: rtl/eecfg_control.sv
module eecfg_control
  import eecfg_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startLoad,
  input  logic          startProg,
  input  logic          mwDone,
  input  logic [AW-1:0] idx,
  input  logic          lastIdx,
  input  logic          sumOk,
  input  logic          sigOk,
  output ctl_t          ctl,
  output logic          mwReq,
  output logic [1:0]    mwOp,
  output logic [AW-1:0] mwAddr,
  output logic          busy,
  output logic          loadDone,
  output logic          imageValid,
  output logic          defaultsUsed
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CHECK, S_WREN, S_WRITE} state_t;
  state_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    mwReq     = 1'b0;
    mwOp      = OP_READ;
    mwAddr    = '0;
    unique case (state)
      S_IDLE: begin
        if (startLoad) begin
          ctl.clrCnt = 1'b1;
          nextState  = S_LOAD;
        end else if (startProg) begin
          ctl.clrCnt = 1'b1;
          nextState  = S_WREN;
        end
      end
      S_LOAD: begin
        mwReq  = 1'b1;
        mwAddr = idx;
        if (mwDone) begin
          ctl.loadStep = 1'b1;
          if (lastIdx) nextState = S_CHECK;
        end
      end
      S_CHECK: begin
        ctl.applyDefaults = !(sumOk && sigOk);
        nextState = S_IDLE;
      end
      S_WREN: begin
        mwReq = 1'b1;
        mwOp  = OP_WREN;
        if (mwDone) nextState = S_WRITE;
      end
      S_WRITE: begin
        mwReq  = 1'b1;
        mwOp   = OP_WRITE;
        mwAddr = idx;
        if (mwDone) begin
          ctl.progStep = 1'b1;
          if (lastIdx) nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      loadDone     <= 1'b0;
      imageValid   <= 1'b0;
      defaultsUsed <= 1'b0;
    end else begin
      state    <= nextState;
      loadDone <= (state == S_CHECK);
      if (state == S_CHECK) begin
        imageValid   <= sumOk && sigOk;
        defaultsUsed <= !(sumOk && sigOk);
      end
    end
  end
endmodule

// File: rtl/eeprom_cfg_validator.sv
module eeprom_cfg_validator
  import eecfg_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startLoad,
  input  logic          startProg,
  output logic          mwReq,
  output logic [1:0]    mwOp,
  output logic [AW-1:0] mwAddr,
  output logic [DW-1:0] mwWData,
  input  logic          mwDone,
  input  logic [DW-1:0] mwRdData,
  input  logic [AW-1:0] hostAddr,
  input  logic          hostWe,
  input  logic [DW-1:0] hostWData,
  output logic [DW-1:0] hostRData,
  output logic          busy,
  output logic          loadDone,
  output logic          imageValid,
  output logic          defaultsUsed,
  output logic [3*DW-1:0] stationAddr
);
  ctl_t          ctl;
  logic [AW-1:0] idx;
  logic          lastIdx, sumOk, sigOk;
  logic [DW-1:0] outWord;

  eecfg_control #(.AW(AW)) u_ctl (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .startProg(startProg),
    .mwDone(mwDone), .idx(idx), .lastIdx(lastIdx), .sumOk(sumOk), .sigOk(sigOk),
    .ctl(ctl), .mwReq(mwReq), .mwOp(mwOp), .mwAddr(mwAddr), .busy(busy),
    .loadDone(loadDone), .imageValid(imageValid), .defaultsUsed(defaultsUsed)
  );

  eecfg_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mwRdData(mwRdData),
    .hostWe(hostWe && !busy), .hostAddr(hostAddr), .hostWData(hostWData),
    .hostRData(hostRData), .idx(idx), .lastIdx(lastIdx), .sumOk(sumOk),
    .sigOk(sigOk), .outWord(outWord), .stationAddr(stationAddr)
  );

  assign mwWData = (mwOp == OP_WRITE) ? outWord : '0;
endmodule

// File: rtl/eecfg_checker.sv
module eecfg_checker #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          mwReq,
  input logic [1:0]    mwOp,
  input logic [AW-1:0] mwAddr,
  input logic [DW-1:0] mwWData,
  input logic          mwDone,
  input logic          busy,
  input logic          loadDone,
  input logic          imageValid,
  input logic          defaultsUsed
);
  localparam logic [AW-1:0] LAST = AW'((1 << AW) - 1);

  assert_hold_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mwReq && !mwDone) |=> (mwReq && $stable(mwOp) && $stable(mwAddr) && $stable(mwWData)));

  assert_read_ascending_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mwReq && mwDone && mwOp == 2'b10 && mwAddr != LAST) |=>
      (mwReq && mwOp == 2'b10 && mwAddr == $past(mwAddr) + 1'b1));

  assert_write_ascending_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mwReq && mwDone && mwOp == 2'b01 && mwAddr != LAST) |=>
      (mwReq && mwOp == 2'b01 && mwAddr == $past(mwAddr) + 1'b1));

  assert_wren_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mwReq && mwDone && mwOp == 2'b11) |=> (mwReq && mwOp == 2'b01 && mwAddr == '0));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (!busy && (imageValid != defaultsUsed)));

  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(imageValid && defaultsUsed));

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    mwReq |-> busy);
endmodule

bind eeprom_cfg_validator eecfg_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .mwReq(mwReq), .mwOp(mwOp), .mwAddr(mwAddr),
  .mwWData(mwWData), .mwDone(mwDone), .busy(busy), .loadDone(loadDone),
  .imageValid(imageValid), .defaultsUsed(defaultsUsed)
);

// File: tb/sim_eeprom_cfg_validator.sv
`timescale 1ns/1ps
module sim_eeprom_cfg_validator;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startLoad = 1'b0, startProg = 1'b0;
  logic mwReq, mwDone = 1'b0;
  logic [1:0] mwOp;
  logic [5:0] mwAddr;
  logic [15:0] mwWData, mwRdData = '0;
  logic [5:0] hostAddr = '0;
  logic hostWe = 1'b0;
  logic [15:0] hostWData = '0, hostRData;
  logic busy, loadDone, imageValid, defaultsUsed;
  logic [47:0] stationAddr;

  int checks = 0, errors = 0;
  logic [15:0] mem [64];
  logic [15:0] expImg [64];
  logic [1:0]  logOp [130];
  logic [5:0]  logAddr [130];
  logic [15:0] logData [130];
  int logCnt = 0;
  int lat = 0;

  always #5 clk = ~clk;

  eeprom_cfg_validator u0 (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .startProg(startProg),
    .mwReq(mwReq), .mwOp(mwOp), .mwAddr(mwAddr), .mwWData(mwWData),
    .mwDone(mwDone), .mwRdData(mwRdData), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWData(hostWData), .hostRData(hostRData), .busy(busy), .loadDone(loadDone),
    .imageValid(imageValid), .defaultsUsed(defaultsUsed), .stationAddr(stationAddr)
  );

  // EEPROM behind a Microwire master: answers each command after 3 cycles
  always @(posedge clk) begin
    if (mwDone) begin
      mwDone <= 1'b0;
      lat    <= 0;
      if (logCnt < 130) begin
        logOp[logCnt] = mwOp; logAddr[logCnt] = mwAddr; logData[logCnt] = mwWData;
      end
      logCnt = logCnt + 1;
      if (mwOp == 2'b01) mem[mwAddr] = mwWData;
    end else if (mwReq) begin
      if (lat == 2) begin
        mwDone   <= 1'b1;
        mwRdData <= mem[mwAddr];
      end
      lat <= lat + 1;
    end
  end

  function automatic logic [15:0] dflt(input int n);
    if (n < 10) return 16'h0000;
    case (n)
      10: return 16'h4E0B; 11: return 16'h1008; 12: return 16'h8086;
      13: return 16'h1008; 14: return 16'h8086; 15: return 16'hF02C;
      32: return 16'hDFDE; 33: return 16'h0002; 34: return 16'h1414;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic buildImage(input logic [15:0] sig, input bit fixSum);
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) begin
      mem[i] = (i == 10) ? sig : 16'(i * 16'h0321 + 16'h1357);
      s += mem[i];
    end
    mem[63] = fixSum ? 16'hBABA - s : 16'h1234;
  endtask

  task automatic runLoad();
    logCnt = 0;
    @(negedge clk) startLoad = 1'b1;
    @(negedge clk) startLoad = 1'b0;
    while (!loadDone) @(negedge clk);
  endtask

  task automatic readBack(input string req);
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      hostAddr = 6'(i);
      #1;
      if (hostRData !== expImg[i]) begin
        if (bad == 0) chk(req, $sformatf("word %0d", i), hostRData, expImg[i]);
        bad++;
      end
    end
    if (bad == 0) chk(req, "image words", 0, 0);
  endtask

  task automatic testReset();
    chk("R1", "busy", busy, 0);
    chk("R1", "mwReq", mwReq, 0);
    chk("R1", "flags", {loadDone, imageValid, defaultsUsed}, 0);
    for (int i = 0; i < 64; i++) expImg[i] = '0;
    readBack("R1");
  endtask

  task automatic testValidLoad();
    int badSeq = 0;
    buildImage(16'h4ABC, 1'b1);
    runLoad();
    chk("R6", "busy at loadDone", busy, 0);
    chk("R3", "imageValid", imageValid, 1);
    chk("R3", "defaultsUsed", defaultsUsed, 0);
    chk("R2", "read count", logCnt, 64);
    for (int i = 0; i < 64; i++)
      if (logOp[i] !== 2'b10 || logAddr[i] !== 6'(i)) badSeq++;
    chk("R2", "read order", badSeq, 0);
    @(negedge clk);
    chk("R6", "loadDone width", loadDone, 0);
    for (int i = 0; i < 64; i++) expImg[i] = mem[i];
    readBack("R3");
    chk("R10", "station", stationAddr, {mem[2], mem[1], mem[0]});
  endtask

  task automatic testHostWrite();
    @(negedge clk) begin hostWe = 1'b1; hostAddr = 6'd1; hostWData = 16'hA5C3; end
    @(negedge clk) hostWe = 1'b0;
    expImg[1] = 16'hA5C3;
    chk("R8", "host write word1", hostRData, 16'hA5C3);
    chk("R10", "station byte 2/3", stationAddr[31:16], 16'hA5C3);
  endtask

  task automatic testProgram();
    logic [15:0] s = '0;
    int bad = 0;
    for (int i = 0; i < 63; i++) s += expImg[i];
    expImg[63] = 16'hBABA - s;
    logCnt = 0;
    @(negedge clk) startProg = 1'b1;
    @(negedge clk) startProg = 1'b0;
    while (busy) @(negedge clk);
    chk("R7", "command count", logCnt, 65);
    chk("R7", "wren cmd", {logOp[0], logAddr[0]}, {2'b11, 6'd0});
    for (int i = 0; i < 64; i++)
      if (logOp[i+1] !== 2'b01 || logAddr[i+1] !== 6'(i) || logData[i+1] !== expImg[i]) bad++;
    chk("R7", "write sequence", bad, 0);
    chk("R7", "eeprom checksum word", mem[63], expImg[63]);
    readBack("R7");
  endtask

  task automatic testBadSum();
    buildImage(16'h4ABC, 1'b1);
    mem[20] ^= 16'h0001;
    runLoad();
    chk("R4", "imageValid", imageValid, 0);
    chk("R4", "defaultsUsed", defaultsUsed, 1);
    for (int i = 0; i < 63; i++) expImg[i] = dflt(i);
    expImg[63] = mem[63];
    readBack("R4");
  endtask

  task automatic testBadSig();
    buildImage(16'h8ABC, 1'b1);
    runLoad();
    chk("R5", "imageValid", imageValid, 0);
    chk("R5", "defaultsUsed", defaultsUsed, 1);
    for (int i = 0; i < 63; i++) expImg[i] = dflt(i);
    expImg[63] = mem[63];
    readBack("R5");
  endtask

  task automatic testBusyBlock();
    buildImage(16'h4777, 1'b1);
    logCnt = 0;
    @(negedge clk) startLoad = 1'b1;
    @(negedge clk) startLoad = 1'b0;
    repeat (5) @(negedge clk);
    hostWe = 1'b1; hostAddr = 6'd5; hostWData = 16'hBEEF; startProg = 1'b1;
    @(negedge clk) begin hostWe = 1'b0; startProg = 1'b0; end
    @(negedge clk) startLoad = 1'b1;
    @(negedge clk) startLoad = 1'b0;
    while (!loadDone) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R9", "no program after busy request", logCnt, 64);
    chk("R9", "still idle", busy, 0);
    for (int i = 0; i < 64; i++) expImg[i] = mem[i];
    readBack("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testValidLoad();
    testHostWrite();
    testProgram();
    testBadSum();
    testBadSig();
    testBusyBlock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule